// File: doc/BRIEF.md
# ECC Error Capture and Reporting

This block watches the error strobes from two ECC-protected memories. Each memory is split into several banks, and each bank can signal a corrected (single-bit) error or an uncorrectable error in any cycle. For each memory the block keeps two report slots: one for corrected errors and one for uncorrectable errors. A slot records the failing bank number, the address, the data word, the check code as it was read from the array, and the syndrome.

Each slot holds the first error it sees until software clears the slot's interrupt flag with a write-one-to-clear strobe. An error that arrives while the flag is set is dropped, and the loss is recorded in the slot's overflow flag. When several banks of one memory report the same kind of error in one cycle, the lowest-numbered bank is the one recorded, and the overflow flag is also raised.

Each flag drives an interrupt line through its own enable bit. The ECC encoder and decoder, and any register decoding for a bus, sit outside this block.

Top module: `ecc_err_capture`

## Requirements
- R1: There are NUM_MEM × 2 slots. Slot index s = 2·m + k, where m is the memory and k is the kind (k=0 corrected, k=1 uncorrectable). Bank b of slot s uses strobe bit s·NUM_BANKS+b and detail field s·NUM_BANKS+b of each detail bus. An event in one slot never changes another slot, including when every slot reports in the same cycle.
- R2: An error strobe that arrives while the slot's interrupt flag is already set leaves the captured bank, address, data, code and syndrome unchanged. It sets the overflow flag on the next cycle.
- R3: An error strobe that arrives while the slot's interrupt flag is clear captures the reporting bank's details on the next clock edge and sets the interrupt flag.
- R4: When several banks of one slot strobe in the same cycle, the captured bank number and details are those of the lowest-numbered strobing bank.
- R5: Strobes from two or more banks of one slot in the same cycle set that slot's overflow flag, even when the interrupt flag was clear.
- R6: Interrupt and overflow flags are sticky. Each clears only on its own write-one-to-clear strobe. When a set condition and a clear strobe occur in the same cycle, the flag ends up set.
- R7: irq_o[s] equals flag s AND irq_en_i[s], and ovf_irq_o[s] equals overflow s AND ovf_irq_en_i[s]. The enables never prevent a flag from being set.
- R8: The captured code is the input code value copied bit for bit, whatever its value (all zeros and all ones included). It is never recomputed.
- R9: A synchronous active-low reset clears every flag and every report field to zero on the first clock edge during which it is low, whatever the strobes are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| err_vld_i | input | NUM_MEM·2·NUM_BANKS | Per-slot, per-bank error strobes |
| err_addr_i | input | NUM_MEM·2·NUM_BANKS·ADDR_W | Failing address, per slot and bank |
| err_data_i | input | NUM_MEM·2·NUM_BANKS·DATA_W | Data word read, per slot and bank |
| err_code_i | input | NUM_MEM·2·NUM_BANKS·CODE_W | Stored check code, per slot and bank |
| err_synd_i | input | NUM_MEM·2·NUM_BANKS·SYND_W | Syndrome, per slot and bank |
| flag_clr_i | input | NUM_MEM·2 | Write-one-to-clear strobes for the interrupt flags |
| ovf_clr_i | input | NUM_MEM·2 | Write-one-to-clear strobes for the overflow flags |
| irq_en_i | input | NUM_MEM·2 | Interrupt enables for the interrupt flags |
| ovf_irq_en_i | input | NUM_MEM·2 | Interrupt enables for the overflow flags |
| rpt_bank_o | output | NUM_MEM·2·BANK_W | Captured bank number per slot |
| rpt_addr_o | output | NUM_MEM·2·ADDR_W | Captured address per slot |
| rpt_data_o | output | NUM_MEM·2·DATA_W | Captured data per slot |
| rpt_code_o | output | NUM_MEM·2·CODE_W | Captured check code per slot |
| rpt_synd_o | output | NUM_MEM·2·SYND_W | Captured syndrome per slot |
| flag_o | output | NUM_MEM·2 | Sticky interrupt flags |
| ovf_o | output | NUM_MEM·2 | Sticky overflow flags |
| irq_o | output | NUM_MEM·2 | Enabled interrupt-flag requests |
| ovf_irq_o | output | NUM_MEM·2 | Enabled overflow requests |

## Verification
The assertions assume a few things about the inputs. Strobes, clears and details are two-valued. A detail field only matters in a cycle where its strobe is high. The reset is held low long enough to reach a clock edge before anything else is checked. The stimulus keeps within these limits: it changes every input only on the falling clock edge, drives defined detail values for every bank every cycle, and starts with several reset cycles. The sweep covers every strobe pattern of one slot, from both a free slot and an occupied slot, with clears and enables driven in the same cycles as errors.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

   localparam int unsigned KINDS = 2;

   typedef enum logic [0:0] {
      KIND_COR = 1'b0,
      KIND_UNC = 1'b1
   } err_kind_e;

   typedef enum int unsigned {
      MULTI_POPCOUNT = 0,
      MULTI_MASK     = 1
   } multi_style_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ecc_bank_pick.sv
module ecc_bank_pick #(
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned MULTI_STYLE = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_BANKS-1:0] vld_i,
   output logic              any_o,
   output logic              multi_o,
   output logic [BANK_W-1:0] sel_o
);

   always_comb begin
      sel_o = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (vld_i[i]) sel_o = BANK_W'(i);
      end
   end

   assign any_o = |vld_i;

   generate
      if (NUM_BANKS == 1) begin : g_single
         assign multi_o = 1'b0;
      end else if (MULTI_STYLE == ecc_cap_pkg::MULTI_POPCOUNT) begin : g_pop
         assign multi_o = ($countones(vld_i) > 1);
      end else begin : g_mask
         logic [NUM_BANKS-1:0] rest;
         assign rest    = vld_i & (vld_i - 1'b1);
         assign multi_o = |rest;
      end
   endgenerate

   // the selected bank strobes and no lower bank does
   logic [NUM_BANKS-1:0] below_sel;
   assign below_sel = (NUM_BANKS'(1) << sel_o) - NUM_BANKS'(1);

   p_lowest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_o |-> (vld_i[sel_o] && ((vld_i & below_sel) == '0)));

   p_multi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      multi_o |-> ($countones(vld_i) >= 2));

endmodule

// File: rtl/ecc_field_mux.sv
module ecc_field_mux #(
   parameter int unsigned NUM_IN = 4,
   parameter int unsigned W      = 8,
   parameter int unsigned SEL_W  = 2
) (
   input  logic [NUM_IN*W-1:0] in_i,
   input  logic [SEL_W-1:0]    sel_i,
   output logic [W-1:0]        out_o
);

   generate
      if (NUM_IN == 1) begin : g_pass
         logic unused_sel;
         assign unused_sel = ^sel_i;
         assign out_o      = in_i;
      end else begin : g_sel
         always_comb begin
            out_o = '0;
            for (int i = 0; i < NUM_IN; i++) begin
               if (sel_i == SEL_W'(i)) out_o = in_i[i*W +: W];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ecc_report_slot.sv
module ecc_report_slot #(
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CODE_W      = 7,
   parameter int unsigned SYND_W      = 7,
   parameter int unsigned MULTI_STYLE = 1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_BANKS-1:0]        vld_i,
   input  logic [NUM_BANKS*ADDR_W-1:0] addr_i,
   input  logic [NUM_BANKS*DATA_W-1:0] data_i,
   input  logic [NUM_BANKS*CODE_W-1:0] code_i,
   input  logic [NUM_BANKS*SYND_W-1:0] synd_i,
   input  logic                        flag_clr_i,
   input  logic                        ovf_clr_i,
   output logic [BANK_W-1:0]           bank_o,
   output logic [ADDR_W-1:0]           addr_o,
   output logic [DATA_W-1:0]           data_o,
   output logic [CODE_W-1:0]           code_o,
   output logic [SYND_W-1:0]           synd_o,
   output logic                        flag_o,
   output logic                        ovf_o
);

   logic              any, multi;
   logic [BANK_W-1:0] sel;
   logic [ADDR_W-1:0] addr_sel;
   logic [DATA_W-1:0] data_sel;
   logic [CODE_W-1:0] code_sel;
   logic [SYND_W-1:0] synd_sel;

   ecc_bank_pick #(
      .NUM_BANKS  (NUM_BANKS),
      .BANK_W     (BANK_W),
      .MULTI_STYLE(MULTI_STYLE)
   ) i_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (vld_i),
      .any_o  (any),
      .multi_o(multi),
      .sel_o  (sel)
   );

   ecc_field_mux #(.NUM_IN(NUM_BANKS), .W(ADDR_W), .SEL_W(BANK_W))
      i_mux_addr (.in_i(addr_i), .sel_i(sel), .out_o(addr_sel));
   ecc_field_mux #(.NUM_IN(NUM_BANKS), .W(DATA_W), .SEL_W(BANK_W))
      i_mux_data (.in_i(data_i), .sel_i(sel), .out_o(data_sel));
   ecc_field_mux #(.NUM_IN(NUM_BANKS), .W(CODE_W), .SEL_W(BANK_W))
      i_mux_code (.in_i(code_i), .sel_i(sel), .out_o(code_sel));
   ecc_field_mux #(.NUM_IN(NUM_BANKS), .W(SYND_W), .SEL_W(BANK_W))
      i_mux_synd (.in_i(synd_i), .sel_i(sel), .out_o(synd_sel));

   logic capture;
   logic lost;
   assign capture = any & ~flag_o;
   assign lost    = any & (flag_o | multi);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         bank_o <= '0;
         addr_o <= '0;
         data_o <= '0;
         code_o <= '0;
         synd_o <= '0;
         flag_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else begin
         if (capture) begin
            bank_o <= sel;
            addr_o <= addr_sel;
            data_o <= data_sel;
            code_o <= code_sel;
            synd_o <= synd_sel;
         end
         flag_o <= any  | (flag_o & ~flag_clr_i);
         ovf_o  <= lost | (ovf_o  & ~ovf_clr_i);
      end
   end

   p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && any) |=> $stable({bank_o, addr_o, data_o, code_o, synd_o}));

   p_lost_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && (vld_i != '0)) |=> ovf_o);

   p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o && (vld_i != '0)) |=> (flag_o && bank_o == $past(sel)));

   p_verbatim_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o && (vld_i != '0)) |=> (code_o == $past(code_i[sel*CODE_W +: CODE_W])));

   p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !flag_clr_i) |=> flag_o);

   p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o && ovf_clr_i && (vld_i == '0)) |=> !ovf_o);

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
   parameter int unsigned NUM_MEM     = 2,
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CODE_W      = 7,
   parameter int unsigned SYND_W      = 7,
   parameter int unsigned MULTI_STYLE = 1,
   localparam int unsigned SLOTS      = NUM_MEM * ecc_cap_pkg::KINDS,
   localparam int unsigned BANK_W     = ecc_cap_pkg::idx_width(NUM_BANKS),
   localparam int unsigned STROBES    = SLOTS * NUM_BANKS
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [STROBES-1:0]        err_vld_i,
   input  logic [STROBES*ADDR_W-1:0] err_addr_i,
   input  logic [STROBES*DATA_W-1:0] err_data_i,
   input  logic [STROBES*CODE_W-1:0] err_code_i,
   input  logic [STROBES*SYND_W-1:0] err_synd_i,
   input  logic [SLOTS-1:0]          flag_clr_i,
   input  logic [SLOTS-1:0]          ovf_clr_i,
   input  logic [SLOTS-1:0]          irq_en_i,
   input  logic [SLOTS-1:0]          ovf_irq_en_i,
   output logic [SLOTS*BANK_W-1:0]   rpt_bank_o,
   output logic [SLOTS*ADDR_W-1:0]   rpt_addr_o,
   output logic [SLOTS*DATA_W-1:0]   rpt_data_o,
   output logic [SLOTS*CODE_W-1:0]   rpt_code_o,
   output logic [SLOTS*SYND_W-1:0]   rpt_synd_o,
   output logic [SLOTS-1:0]          flag_o,
   output logic [SLOTS-1:0]          ovf_o,
   output logic [SLOTS-1:0]          irq_o,
   output logic [SLOTS-1:0]          ovf_irq_o
);

   generate
      if (NUM_MEM < 1) begin : g_bad_mem
         $error("ecc_err_capture: NUM_MEM must be at least 1");
      end
      if (NUM_BANKS < 1 || NUM_BANKS > 64) begin : g_bad_banks
         $error("ecc_err_capture: NUM_BANKS must lie in 1..64");
      end
      if (ADDR_W < 1 || DATA_W < 1 || CODE_W < 1 || SYND_W < 1) begin : g_bad_w
         $error("ecc_err_capture: every field width must be non-zero");
      end
      if (MULTI_STYLE > 1) begin : g_bad_style
         $error("ecc_err_capture: MULTI_STYLE must be 0 or 1");
      end
   endgenerate

   for (genvar gs = 0; gs < SLOTS; gs++) begin : g_slot
      localparam int unsigned B0 = gs * NUM_BANKS;

      ecc_report_slot #(
         .NUM_BANKS  (NUM_BANKS),
         .BANK_W     (BANK_W),
         .ADDR_W     (ADDR_W),
         .DATA_W     (DATA_W),
         .CODE_W     (CODE_W),
         .SYND_W     (SYND_W),
         .MULTI_STYLE(MULTI_STYLE)
      ) i_slot (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .vld_i     (err_vld_i [B0 +: NUM_BANKS]),
         .addr_i    (err_addr_i[B0*ADDR_W +: NUM_BANKS*ADDR_W]),
         .data_i    (err_data_i[B0*DATA_W +: NUM_BANKS*DATA_W]),
         .code_i    (err_code_i[B0*CODE_W +: NUM_BANKS*CODE_W]),
         .synd_i    (err_synd_i[B0*SYND_W +: NUM_BANKS*SYND_W]),
         .flag_clr_i(flag_clr_i[gs]),
         .ovf_clr_i (ovf_clr_i[gs]),
         .bank_o    (rpt_bank_o[gs*BANK_W +: BANK_W]),
         .addr_o    (rpt_addr_o[gs*ADDR_W +: ADDR_W]),
         .data_o    (rpt_data_o[gs*DATA_W +: DATA_W]),
         .code_o    (rpt_code_o[gs*CODE_W +: CODE_W]),
         .synd_o    (rpt_synd_o[gs*SYND_W +: SYND_W]),
         .flag_o    (flag_o[gs]),
         .ovf_o     (ovf_o[gs])
      );

      // a slot reacts only to its own strobes
      p_isolated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ((err_vld_i[B0 +: NUM_BANKS] == '0) && !flag_clr_i[gs])
            |=> (flag_o[gs] == $past(flag_o[gs])));
   end

   assign irq_o     = flag_o & irq_en_i;
   assign ovf_irq_o = ovf_o  & ovf_irq_en_i;

   p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_en_i == '0) |-> (irq_o == '0));

endmodule

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;

   localparam int NM = 2;
   localparam int NB = 4;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int CW = 5;
   localparam int SW = 5;
   localparam int SL = NM * 2;
   localparam int BW = 2;
   localparam int ST = SL * NB;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n;
   logic [ST-1:0]   err_vld;
   logic [ST*AW-1:0] err_addr;
   logic [ST*DW-1:0] err_data;
   logic [ST*CW-1:0] err_code;
   logic [ST*SW-1:0] err_synd;
   logic [SL-1:0]   flag_clr, ovf_clr, irq_en, ovf_irq_en;
   logic [SL*BW-1:0] rpt_bank;
   logic [SL*AW-1:0] rpt_addr;
   logic [SL*DW-1:0] rpt_data;
   logic [SL*CW-1:0] rpt_code;
   logic [SL*SW-1:0] rpt_synd;
   logic [SL-1:0]   flag, ovf, irq, ovf_irq;

   ecc_err_capture #(
      .NUM_MEM(NM), .NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW),
      .CODE_W(CW), .SYND_W(SW), .MULTI_STYLE(1)
   ) i_ecc_err_capture (
      .clk_i(clk), .rst_ni(rst_n),
      .err_vld_i(err_vld), .err_addr_i(err_addr), .err_data_i(err_data),
      .err_code_i(err_code), .err_synd_i(err_synd),
      .flag_clr_i(flag_clr), .ovf_clr_i(ovf_clr),
      .irq_en_i(irq_en), .ovf_irq_en_i(ovf_irq_en),
      .rpt_bank_o(rpt_bank), .rpt_addr_o(rpt_addr), .rpt_data_o(rpt_data),
      .rpt_code_o(rpt_code), .rpt_synd_o(rpt_synd),
      .flag_o(flag), .ovf_o(ovf), .irq_o(irq), .ovf_irq_o(ovf_irq)
   );

   int total = 0;
   int bad   = 0;
   int tstep = 0;
   bit done  = 1'b0;

   bit m_flag [SL];
   bit m_ovf  [SL];
   bit m_ien  [SL];
   bit m_oen  [SL];
   int m_bank [SL];
   int m_addr [SL];
   int m_data [SL];
   int m_code [SL];
   int m_synd [SL];

   function automatic int f_addr(int s, int b, int t);
      return (s * 53 + b * 17 + t * 3 + 1) % (1 << AW);
   endfunction
   function automatic int f_data(int s, int b, int t);
      return (s * 29 + b * 71 + t * 7) % (1 << DW);
   endfunction
   function automatic int f_code(int b, int t);
      return (t + b) % (1 << CW);
   endfunction
   function automatic int f_synd(int s, int b, int t);
      return (s * 5 + b * 9 + t * 11 + 3) % (1 << SW);
   endfunction

   task automatic chk(input string req, input string what, input int s,
                      input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s slot %0d: actual=%0d expected=%0d", req, what, s, act, exp);
      end
   endtask

   task automatic step(input logic rst, input logic [ST-1:0] v,
                       input logic [SL-1:0] fc, input logic [SL-1:0] oc,
                       input logic [SL-1:0] ie, input logic [SL-1:0] oe);
      rst_n = rst; err_vld = v; flag_clr = fc; ovf_clr = oc;
      irq_en = ie; ovf_irq_en = oe;
      for (int s = 0; s < SL; s++) begin
         for (int b = 0; b < NB; b++) begin
            err_addr[(s*NB+b)*AW +: AW] = AW'(f_addr(s, b, tstep));
            err_data[(s*NB+b)*DW +: DW] = DW'(f_data(s, b, tstep));
            err_code[(s*NB+b)*CW +: CW] = CW'(f_code(b, tstep));
            err_synd[(s*NB+b)*SW +: SW] = SW'(f_synd(s, b, tstep));
         end
      end
      @(posedge clk);
      for (int s = 0; s < SL; s++) begin
         int cnt = 0;
         int lo  = 0;
         bit nf, no;
         for (int b = NB - 1; b >= 0; b--) begin
            if (v[s*NB+b]) begin cnt++; lo = b; end
         end
         m_ien[s] = ie[s];
         m_oen[s] = oe[s];
         if (!rst) begin
            m_flag[s] = 0; m_ovf[s] = 0; m_bank[s] = 0; m_addr[s] = 0;
            m_data[s] = 0; m_code[s] = 0; m_synd[s] = 0;
         end else begin
            if (cnt > 0 && !m_flag[s]) begin
               m_bank[s] = lo;
               m_addr[s] = f_addr(s, lo, tstep);
               m_data[s] = f_data(s, lo, tstep);
               m_code[s] = f_code(lo, tstep);
               m_synd[s] = f_synd(s, lo, tstep);
            end
            no = (cnt > 0 && (m_flag[s] || cnt > 1)) || (m_ovf[s] && !oc[s]);
            nf = (cnt > 0) || (m_flag[s] && !fc[s]);
            m_flag[s] = nf;
            m_ovf[s]  = no;
         end
      end
      @(negedge clk);
      tstep++;
   endtask

   task automatic compare(input string tag);
      for (int s = 0; s < SL; s++) begin
         chk(tag, "flag", s, int'(flag[s]), int'(m_flag[s]));
         chk(tag, "overflow", s, int'(ovf[s]), int'(m_ovf[s]));
         chk("R7", "irq", s, int'(irq[s]), int'(m_flag[s] & m_ien[s]));
         chk("R7", "ovf_irq", s, int'(ovf_irq[s]), int'(m_ovf[s] & m_oen[s]));
         chk(tag, "bank", s, int'(rpt_bank[s*BW +: BW]), m_bank[s]);
         chk(tag, "addr", s, int'(rpt_addr[s*AW +: AW]), m_addr[s]);
         chk(tag, "data", s, int'(rpt_data[s*DW +: DW]), m_data[s]);
         chk({tag, " R8"}, "code", s, int'(rpt_code[s*CW +: CW]), m_code[s]);
         chk(tag, "synd", s, int'(rpt_synd[s*SW +: SW]), m_synd[s]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [SL-1:0] all1;
      logic [SL-1:0] none;
      all1 = '1;
      none = '0;
      rst_n = 1'b0; err_vld = '0; flag_clr = '0; ovf_clr = '0;
      irq_en = '0; ovf_irq_en = '0; err_addr = '0; err_data = '0;
      err_code = '0; err_synd = '0;
      @(negedge clk);

      // R9: reset with strobes active
      for (int i = 0; i < 3; i++) begin
         step(1'b0, '1, none, none, all1, all1);
         compare("R9");
      end

      // sweep every pattern of every slot, free and occupied (R2 R3 R4 R5 R1)
      for (int s = 0; s < SL; s++) begin
         for (int pre = 0; pre < 2; pre++) begin
            for (int pat = 1; pat < (1 << NB); pat++) begin
               logic [ST-1:0] v;
               step(1'b1, '0, all1, all1, SL'(tstep), ~SL'(tstep));
               compare("R6");
               if (pre == 1) begin
                  v = '0;
                  v[s*NB + (pat % NB)] = 1'b1;
                  step(1'b1, v, none, none, SL'(tstep), ~SL'(tstep));
                  compare("R3");
               end
               v = '0;
               v[s*NB +: NB] = NB'(pat);
               step(1'b1, v, none, none, SL'(tstep), ~SL'(tstep));
               if (pre == 1)                compare("R2");
               else if ($countones(pat) > 1) compare("R5");
               else                          compare("R4");
            end
         end
      end

      // R1: all slots strobe at once, kinds of one memory independent
      step(1'b1, '0, all1, all1, all1, all1);
      compare("R1");
      step(1'b1, {SL{4'b0110}}, none, none, all1, all1);
      compare("R1");
      step(1'b1, {SL{4'b1000}}, none, none, all1, all1);
      compare("R1");

      // R6: set beats clear in the same cycle
      step(1'b1, '0, all1, all1, all1, all1);
      compare("R6");
      step(1'b1, ST'(4'b0100) << (2*NB), none, none, all1, all1);
      compare("R6");
      step(1'b1, ST'(4'b0001) << (2*NB), SL'(4), none, all1, all1);
      compare("R6");
      step(1'b1, ST'(4'b0010) << (2*NB), none, SL'(4), all1, all1);
      compare("R6");
      step(1'b1, '0, SL'(4), none, all1, all1);
      compare("R6");
      step(1'b1, '0, none, SL'(4), all1, all1);
      compare("R6");

      // R7: enables off, flags still set
      step(1'b1, {SL{4'b0011}}, none, none, none, none);
      compare("R7");
      step(1'b1, '0, none, none, all1, none);
      compare("R7");

      // R9: reset after activity
      step(1'b0, '0, none, none, all1, all1);
      compare("R9");
      step(1'b1, '0, none, none, all1, all1);
      compare("R9");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule